// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Drive Controller

This block is the clocked sequencing logic for a half-bridge power stage. It receives an already-digitised PWM command with three levels (high, low and a mid-level shutdown window). It also takes an enable level, a low-side enable level, two supply-undervoltage flags and two comparator flags. From these it produces a high-side and a low-side gate enable that are never on together. All timing is counted in clock cycles and set by parameters.

The low-side turn-on is adaptive. After the high side has turned off, the low side waits until the switch-node comparator has reported "below threshold" for a set number of cycles. As a second path, it waits until the high-side gate-source comparator has reported "discharged" for a longer set number of cycles. Whichever path completes first turns the low side on. The high side turns on only after the low side has been off for a programmed gap. A mid-level PWM input that persists for the hold-off time parks both gates. A shorter mid-level excursion keeps the last valid command. Every asynchronous input passes a two-flop synchroniser before use.

Top module: `gdrv_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both gate outputs are low.
- R2: The high-side and low-side outputs are never high in the same cycle.
- R3: A PWM level code of 2'b10 (high) turns the high side on 4 cycles after the input changes. This needs the low side to have been off long enough, the bootstrap supply to be good and the enable to be active.
- R4: Once the decoded command leaves high, the high side stays on for HS_OFF_DLY further cycles (decode happens 3 cycles after the input change). An enable or bias-supply fault instead turns it off 3 cycles after that input changes.
- R5: With a low command (code 2'b01) and the high side off, the low side turns on after the switch-node-low flag has been seen for LS_SW_DLY+1 consecutive synchronised cycles.
- R6: With a low command, a gate-discharged flag seen for LS_VGS_DLY+1 consecutive cycles turns the low side on regardless of the switch-node flag.
- R7: The low side turns off 4 cycles after PWM leaves low. The high side turns on only after the low side has been off for DT_GAP+1 cycles.
- R8: A mid-level code (2'b00 or 2'b11) lasting at least HOLD_CYC synchronised cycles parks both gates off. Shorter excursions leave the previous command in force.
- R9: An enable level other than 2'b10 (low 2'b01 or open 2'b00) forces both gates off 3 cycles after the change. Restoring 2'b10 resumes normal control.
- R10: A low-side enable level of 2'b01 forces only the low side off. High (2'b10) or open (2'b00) has no effect on it.
- R11: A set bias-supply undervoltage flag forces both gates off 3 cycles after it rises.
- R12: A set bootstrap undervoltage flag prevents the high side from turning on. Clearing it lets a pending high command turn the high side on 3 cycles later.
- R13: After reset, no gate turns on until PWM has been seen at a valid high or low code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_lvl_i | input | 2 | PWM level code: 10 high, 01 low, 00/11 mid window |
| en_lvl_i | input | 2 | Stage enable level code: 10 run, 01 or 00 shut down |
| lsen_lvl_i | input | 2 | Low-side enable level code: 01 blocks low side |
| uvlo_bias_i | input | 1 | Bias-supply undervoltage flag |
| uvlo_boot_i | input | 1 | Bootstrap-supply undervoltage flag |
| sw_low_i | input | 1 | Switch node below threshold |
| hs_vgs_low_i | input | 1 | High-side gate-source voltage below threshold |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |

## Verification
Two functions can fall in the same cycle. One is the release of a forced shutdown (enable, low-side enable or bias fault). The other is the low-side qualification counter, which keeps running through the shutdown. When the force lifts, the low side must come back in that same cycle, with no second qualification delay. The bench provokes this by dropping and restoring each fault while the switch-node flag is held low and the command is low. A scoreboard then compares the exact cycle of every gate edge against a figure computed from the requirement. A second collision, between the mid-window hold-off expiring and the high-side turn-off delay, is judged the same way.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

  typedef enum logic [1:0] {
    LVL_OPEN = 2'b00,
    LVL_LOW  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_BAD  = 2'b11
  } lvl_e;

  typedef enum logic [1:0] {
    CMD_PARK = 2'b00,
    CMD_LS   = 2'b01,
    CMD_HS   = 2'b10
  } cmd_e;

endpackage

// File: rtl/gdrv_sync.sv
module gdrv_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/gdrv_pwm_dec.sv
module gdrv_pwm_dec
  import gdrv_pkg::*;
#(
  parameter int HOLD_CYC = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] lvl_i,
  output cmd_e       cmd_o
);

  localparam int HW = $clog2(HOLD_CYC + 1);

  logic [HW-1:0] mid_cnt;
  cmd_e          cmd_q;

  // mid window holds the last valid command until the hold-off expires
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= CMD_PARK;
      mid_cnt <= '0;
    end else if (lvl_i == LVL_HIGH) begin
      cmd_q   <= CMD_HS;
      mid_cnt <= '0;
    end else if (lvl_i == LVL_LOW) begin
      cmd_q   <= CMD_LS;
      mid_cnt <= '0;
    end else if (mid_cnt >= HW'(HOLD_CYC - 1)) begin
      cmd_q   <= CMD_PARK;
    end else begin
      mid_cnt <= mid_cnt + 1'b1;
    end
  end

  assign cmd_o = cmd_q;

  p_park_from_mid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_PARK && $past(cmd_q) != CMD_PARK)
      |-> ($past(lvl_i) != LVL_HIGH && $past(lvl_i) != LVL_LOW));

  p_valid_level_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q != CMD_PARK && $past(cmd_q) != cmd_q)
      |-> ($past(lvl_i) == ((cmd_q == CMD_HS) ? LVL_HIGH : LVL_LOW)));

endmodule

// File: rtl/gdrv_qual_cnt.sv
module gdrv_qual_cnt #(
  parameter int LIM = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);

  localparam int W = $clog2(LIM + 2);

  logic [W-1:0] cnt;

  // consecutive-cycle counter, saturating at LIM
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt <= '0;
    else if (!run_i)           cnt <= '0;
    else if (cnt < W'(LIM))    cnt <= cnt + 1'b1;
  end

  assign done_o = (cnt >= W'(LIM));

  // bound shared by the R5 and R6 qualification paths
  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= W'(LIM));

endmodule

// File: rtl/gdrv_seq.sv
module gdrv_seq
  import gdrv_pkg::*;
#(
  parameter int HS_OFF_DLY = 3,
  parameter int LS_SW_DLY  = 2,
  parameter int LS_VGS_DLY = 6,
  parameter int DT_GAP     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  cmd_e cmd_i,
  input  logic force_off_i,
  input  logic ls_block_i,
  input  logic hs_block_i,
  input  logic sw_low_i,
  input  logic vgs_low_i,
  output logic hs_on_o,
  output logic ls_on_o
);

  localparam int OFF_LIM = (HS_OFF_DLY > 0) ? HS_OFF_DLY - 1 : 0;

  logic hs_q, ls_q, hs_d, ls_d;
  logic gap_run, gap_done;
  logic off_run, off_done;
  logic sw_run,  sw_done;
  logic vg_run,  vg_done;

  assign gap_run = !ls_q;
  assign off_run = hs_q && (cmd_i != CMD_HS);
  assign sw_run  = (cmd_i == CMD_LS) && !hs_q && !ls_q && sw_low_i;
  assign vg_run  = (cmd_i == CMD_LS) && !hs_q && !ls_q && vgs_low_i;

  gdrv_qual_cnt #(.LIM(DT_GAP)) u_gap (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(gap_run), .done_o(gap_done));

  gdrv_qual_cnt #(.LIM(OFF_LIM)) u_hs_off (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(off_run), .done_o(off_done));

  gdrv_qual_cnt #(.LIM(LS_SW_DLY)) u_sw (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(sw_run), .done_o(sw_done));

  gdrv_qual_cnt #(.LIM(LS_VGS_DLY)) u_vgs (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(vg_run), .done_o(vg_done));

  always_comb begin
    if (force_off_i)  hs_d = 1'b0;
    else if (hs_q)    hs_d = !(off_run && off_done);
    else              hs_d = (cmd_i == CMD_HS) && !hs_block_i && gap_run && gap_done;

    if (force_off_i || ls_block_i || cmd_i != CMD_LS) ls_d = 1'b0;
    else if (ls_q)    ls_d = 1'b1;
    else              ls_d = !hs_q && ((sw_run && sw_done) || (vg_run && vg_done));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q <= 1'b0;
      ls_q <= 1'b0;
    end else begin
      hs_q <= hs_d;
      ls_q <= ls_d;
    end
  end

  assign hs_on_o = hs_q;
  assign ls_on_o = ls_q;

  p_no_overlap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_q && ls_q));

  p_hs_fall_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_q) |-> ($past(force_off_i) || $past(cmd_i) != CMD_HS));

  // covers both qualification paths of R5 and R6
  p_ls_rise_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_q) |-> ($past(cmd_i) == CMD_LS && !$past(hs_q)));

  p_gap_before_hs_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_q) |-> $past(gap_done));

  // force_off merges the enable level (R9) and bias undervoltage (R11)
  p_force_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_off_i |=> (!hs_q && !ls_q));

  p_ls_block_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ls_block_i |=> !ls_q);

  p_boot_block_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_block_i && !hs_q) |=> !hs_q);

endmodule

// File: rtl/gdrv_ctrl.sv
module gdrv_ctrl
  import gdrv_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 8,
  parameter int HS_OFF_DLY  = 3,
  parameter int LS_SW_DLY   = 2,
  parameter int LS_VGS_DLY  = 6,
  parameter int DT_GAP      = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] pwm_lvl_i,
  input  logic [1:0] en_lvl_i,
  input  logic [1:0] lsen_lvl_i,
  input  logic       uvlo_bias_i,
  input  logic       uvlo_boot_i,
  input  logic       sw_low_i,
  input  logic       hs_vgs_low_i,
  output logic       hs_gate_o,
  output logic       ls_gate_o
);

  localparam int SW = 10;
  // undervoltage flags come out of reset asserted
  localparam logic [SW-1:0] SYNC_RST = {2'b00, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0};

  logic [SW-1:0] raw, syn;
  logic [1:0]    s_pwm, s_en, s_lsen;
  logic          s_bias, s_boot, s_sw, s_vgs;
  logic          force_off, ls_block;
  cmd_e          cmd;

  assign raw = {pwm_lvl_i, en_lvl_i, lsen_lvl_i, uvlo_bias_i, uvlo_boot_i, sw_low_i, hs_vgs_low_i};

  gdrv_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn));

  assign {s_pwm, s_en, s_lsen, s_bias, s_boot, s_sw, s_vgs} = syn;

  assign force_off = (s_en != LVL_HIGH) || s_bias;
  assign ls_block  = (s_lsen == LVL_LOW);

  gdrv_pwm_dec #(.HOLD_CYC(HOLD_CYC)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(s_pwm), .cmd_o(cmd));

  gdrv_seq #(
    .HS_OFF_DLY(HS_OFF_DLY), .LS_SW_DLY(LS_SW_DLY),
    .LS_VGS_DLY(LS_VGS_DLY), .DT_GAP(DT_GAP)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd),
    .force_off_i (force_off),
    .ls_block_i  (ls_block),
    .hs_block_i  (s_boot),
    .sw_low_i    (s_sw),
    .vgs_low_i   (s_vgs),
    .hs_on_o     (hs_gate_o),
    .ls_on_o     (ls_gate_o)
  );

endmodule

// File: tb/gdrv_ctrl_tb.sv
module gdrv_ctrl_tb;

  localparam int T_CLK  = 10;
  localparam int HOLD   = 8;
  localparam int HS_OFF = 3;
  localparam int SWD    = 2;
  localparam int VGSD   = 6;
  localparam int GAP    = 4;
  localparam logic [1:0] HI = 2'b10, LO = 2'b01, OPN = 2'b00;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] pwm = OPN, en = OPN, lsen = HI;
  logic       bias = 1'b1, boot = 1'b1, sw = 1'b0, vgs = 1'b0;
  logic       hs, ls;

  int cyc = 0;
  int n_vec = 0;
  int n_bad = 0;
  bit hs_prev = 1'b0, ls_prev = 1'b0;
  bit done = 1'b0;

  bit    q_hs[$];
  bit    q_val[$];
  int    q_at[$];
  string q_tag[$];

  gdrv_ctrl #(
    .SYNC_STAGES(2), .HOLD_CYC(HOLD), .HS_OFF_DLY(HS_OFF),
    .LS_SW_DLY(SWD), .LS_VGS_DLY(VGSD), .DT_GAP(GAP)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pwm_lvl_i(pwm), .en_lvl_i(en),
    .lsen_lvl_i(lsen), .uvlo_bias_i(bias), .uvlo_boot_i(boot),
    .sw_low_i(sw), .hs_vgs_low_i(vgs), .hs_gate_o(hs), .ls_gate_o(ls)
  );

  always #(T_CLK/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input bit is_hs, input bit v, input int at, input string tag);
    q_hs.push_back(is_hs); q_val.push_back(v); q_at.push_back(at); q_tag.push_back(tag);
  endtask

  task automatic take(input bit is_hs, input bit v);
    bit e_hs, e_v; int e_at; string e_tag;
    n_vec++;
    if (q_hs.size() == 0) begin
      n_bad++;
      $display("FAIL unexpected edge: %s=%0d at cycle %0d, expected no edge",
               is_hs ? "hs" : "ls", v, cyc);
    end else begin
      e_hs = q_hs.pop_front(); e_v = q_val.pop_front();
      e_at = q_at.pop_front(); e_tag = q_tag.pop_front();
      if (e_hs != is_hs || e_v != v || e_at != cyc) begin
        n_bad++;
        $display("FAIL %s: got %s=%0d at cycle %0d, expected %s=%0d at cycle %0d",
                 e_tag, is_hs ? "hs" : "ls", v, cyc, e_hs ? "hs" : "ls", e_v, e_at);
      end
    end
  endtask

  task automatic chk(input bit got, input bit exp, input string tag);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d, expected %0d at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every gate edge is matched against the scoreboard queue
  always @(negedge clk) begin
    if (rst_ni) begin
      if (hs && ls) begin
        n_vec++; n_bad++;
        $display("FAIL R2: got hs=1 ls=1 at cycle %0d, expected not both", cyc);
      end
      if (hs != hs_prev) take(1'b1, hs);
      if (ls != ls_prev) take(1'b0, ls);
    end
    hs_prev = hs;
    ls_prev = ls;
  end

  initial begin
    int c;
    step(4);
    chk(hs, 1'b0, "R1 hs in reset");
    chk(ls, 1'b0, "R1 ls in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk(hs, 1'b0, "R1 hs after reset");
    chk(ls, 1'b0, "R1 ls after reset");

    // R13: everything ready but PWM still open
    en = HI; bias = 1'b0; boot = 1'b0; sw = 1'b1; vgs = 1'b1;
    step(12);
    chk(hs, 1'b0, "R13 hs open pwm");
    chk(ls, 1'b0, "R13 ls open pwm");

    // R3
    c = cyc; pwm = HI; sw = 1'b0; vgs = 1'b0;
    push(1, 1, c + 4, "R3");
    step(15);

    // R4 + R5: switch-node path
    c = cyc; pwm = LO; sw = 1'b1;
    push(1, 0, c + 3 + HS_OFF, "R4");
    push(0, 1, c + 3 + HS_OFF + SWD + 1, "R5");
    step(20);

    // R7: low side off, gap before high side
    c = cyc; pwm = HI; sw = 1'b0;
    push(0, 0, c + 4, "R7 ls off");
    push(1, 1, c + 4 + GAP + 1, "R7 gap");
    step(20);

    // R6: gate-discharge path only
    c = cyc; pwm = LO; vgs = 1'b1;
    push(1, 0, c + 3 + HS_OFF, "R4");
    push(0, 1, c + 3 + HS_OFF + VGSD + 1, "R6");
    step(25);

    c = cyc; pwm = HI; vgs = 1'b0;
    push(0, 0, c + 4, "R7 ls off");
    push(1, 1, c + 4 + GAP + 1, "R7 gap");
    step(20);

    // R5: no comparator flag, low side must stay off
    c = cyc; pwm = LO;
    push(1, 0, c + 3 + HS_OFF, "R4");
    step(30);
    chk(ls, 1'b0, "R5 no flag no turn-on");

    // R8: short mid excursion ignored, long one parks
    c = cyc; pwm = HI;
    push(1, 1, c + 4, "R3");
    step(15);
    pwm = OPN;
    step(HOLD - 2);
    pwm = HI;
    step(15);
    chk(hs, 1'b1, "R8 short mid ignored");
    c = cyc; pwm = OPN; sw = 1'b1;
    push(1, 0, c + 2 + HOLD + HS_OFF, "R8 park");
    step(30);
    chk(ls, 1'b0, "R8 park holds ls off");

    c = cyc; pwm = LO;
    push(0, 1, c + 3 + SWD + 1, "R5");
    step(15);

    // R9: enable low then open, each released
    c = cyc; en = LO;  push(0, 0, c + 3, "R9 en low");  step(10);
    c = cyc; en = HI;  push(0, 1, c + 3, "R9 en high"); step(10);
    c = cyc; en = OPN; push(0, 0, c + 3, "R9 en open"); step(10);
    c = cyc; en = HI;  push(0, 1, c + 3, "R9 en high"); step(10);

    // R10
    c = cyc; lsen = LO;  push(0, 0, c + 3, "R10 lsen low");  step(10);
    c = cyc; lsen = OPN; push(0, 1, c + 3, "R10 lsen open"); step(10);
    chk(ls, 1'b1, "R10 open no effect");
    lsen = HI; step(10);
    chk(ls, 1'b1, "R10 high no effect");

    // R11
    c = cyc; bias = 1'b1; push(0, 0, c + 3, "R11"); step(10);
    c = cyc; bias = 1'b0; push(0, 1, c + 3, "R11"); step(10);

    // R12
    boot = 1'b1; step(5);
    c = cyc; pwm = HI; sw = 1'b0;
    push(0, 0, c + 4, "R7 ls off");
    step(20);
    chk(hs, 1'b0, "R12 boot blocks hs");
    c = cyc; boot = 1'b0; push(1, 1, c + 3, "R12 release"); step(10);

    // R9 / R11 with the high side on
    c = cyc; en = LO;  push(1, 0, c + 3, "R9 hs forced");  step(10);
    c = cyc; en = HI;  push(1, 1, c + 3, "R9 hs resume");  step(10);
    c = cyc; bias = 1'b1; push(1, 0, c + 3, "R11 hs forced"); step(10);
    c = cyc; bias = 1'b0; push(1, 1, c + 3, "R11 hs resume"); step(10);

    while (q_hs.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL %s: got no edge, expected %s=%0d at cycle %0d",
               q_tag.pop_front(), q_hs.pop_front() ? "hs" : "ls",
               q_val.pop_front(), q_at.pop_front());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got hang at cycle %0d, expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule